// File: doc/BRIEF.md
# Reshapeable Dual-Clock Memory Block

This block holds 1,152 bits of storage behind one write-only port and one read-only port. Each port has its own clock. A two-bit shape input arranges the same storage as 64 words of 18 bits, 128 words of 9 bits, 256 words of 4 bits or 512 words of 2 bits. Both data buses are 18 bits wide. A narrower shape uses only the low lanes of each bus.

A static select picks the read behaviour. In clocked mode, the read address and the read enable are sampled on the read clock, and the result comes out of an output register. In direct mode, the read data follows the read address through logic alone, with no clock. Changing the shape does not erase the storage. The same bits can therefore be written as one shape and read back as another.

Top module: `shaped_dpram`

## Requirements
- R1: The shape code selects the arrangement: 0 gives 64 words of 18 bits, 1 gives 128 of 9, 2 gives 256 of 4, and 3 gives 512 of 2.
- R2: Word k of width W occupies storage bits k*W up to k*W+W-1. With shape 2 or 3, bits 1,024 to 1,151 can neither be written nor read.
- R3: Address bits above those that the current shape needs (6, 7, 8 or 9 bits) are ignored by both ports.
- R4: Read data bits at or above the current word width are zero, and write data bits at or above that width are ignored.
- R5: A write happens only on a rising write clock edge with the write enable high. With the enable low, the storage is unchanged.
- R6: In clocked read mode, with the read enable high at a rising read clock edge, the read data shows the addressed word right after that edge.
- R7: In clocked read mode, with the read enable low at a read clock edge, the read data keeps its previous value.
- R8: In direct read mode, the read data follows the read address and the storage contents with no clock edge.
- R9: In clocked read mode, when the read and write ports hit the same word on the same edge, the read returns the contents from before the write.
- R10: Changing the shape leaves the storage unchanged. Data written in one shape can be read back in another, following the R2 bit mapping.
- R11: While the active-low read reset is low, the clocked read register clears to zero on each read clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low lanes used |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Active-low clear of the read register |
| rd_en | input | 1 | Read enable (clocked mode) |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 18 | Read data |
| shape | input | 2 | Word shape code |
| direct_rd | input | 1 | 1 selects the unclocked read path |

## Verification
The bench exercises every shape with walking, alternating and address-derived data. A wrong word width or a wrong bit offset shows up in these reads. One bit pattern is written as 18-bit words and then read as 2-bit and 4-bit words, which separates a correct bit mapping from a per-shape private layout. Two further patterns cover the address inputs. Writes to addresses with high garbage bits, and reads at the same word from both ports, test the address masking and the read-before-write order. Toggling the read address between clock edges in direct mode tells the unclocked path apart from the registered one.

// File: rtl/shaped_dpram.sv
module shaped_dpram #(
  parameter int TOTAL = 1152,
  parameter int DW    = 18,
  parameter int AW    = 9
) (
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    shape,
  input  logic          direct_rd
);
  localparam int IW = $clog2(TOTAL);

  function automatic logic [4:0] lane_w(input logic [1:0] s);
    case (s)
      2'd0:    return 5'd18;
      2'd1:    return 5'd9;
      2'd2:    return 5'd4;
      default: return 5'd2;
    endcase
  endfunction

  function automatic logic [AW-1:0] amask(input logic [1:0] s);
    return AW'((1 << (6 + int'(s))) - 1);
  endfunction

  logic [TOTAL-1:0] mem;
  logic [DW-1:0]    rword, rq;
  logic [4:0]       w;
  logic [IW-1:0]    wbase, rbase;

  assign w     = lane_w(shape);
  assign wbase = IW'(wr_addr & amask(shape)) * IW'(w);
  assign rbase = IW'(rd_addr & amask(shape)) * IW'(w);

  always_ff @(posedge wclk)
    if (wr_en)
      for (int i = 0; i < DW; i++)
        if (i < int'(w)) mem[wbase + IW'(i)] <= wr_data[i];

  always_comb begin
    rword = '0;
    for (int i = 0; i < DW; i++)
      if (i < int'(w)) rword[i] = mem[rbase + IW'(i)];
  end

  always_ff @(posedge rclk)
    if (!rrst_n)    rq <= '0;
    else if (rd_en) rq <= rword;

  assign rd_data = direct_rd ? rword : rq;

  // R5
  no_write_chk: assert property (@(posedge wclk) !wr_en |=> $stable(mem));
  // R2
  upper_unreached_chk: assert property (@(posedge wclk) shape[1] |=> $stable(mem[TOTAL-1:1024]));
  // R7
  hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    ($past(rrst_n) && !$past(rd_en)) |-> rq == $past(rq));
  // R4
  zero_lane_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $past(rd_en) |-> (rq >> lane_w($past(shape))) == '0);
  // R11
  reset_clear_chk: assert property (@(posedge rclk) !rrst_n |=> rq == '0);
endmodule

// File: tb/tb_shaped_dpram.sv
module tb_shaped_dpram;
  logic clk = 0;
  always #4 clk = ~clk;

  logic wr_en = 0, rrst_n = 0, rd_en = 0, direct_rd = 0;
  logic [8:0] wr_addr = 0, rd_addr = 0;
  logic [17:0] wr_data = 0;
  logic [1:0] shape = 0;
  logic [17:0] rd_data;

  shaped_dpram dut (.wclk(clk), .wr_en, .wr_addr, .wr_data, .rclk(clk), .rrst_n,
    .rd_en, .rd_addr, .rd_data, .shape, .direct_rd);

  bit model [1152];
  logic [17:0] exp_q = 0;
  int checks = 0, errors = 0;
  string tag = "R6";

  function automatic int wid(input logic [1:0] s);
    return s == 0 ? 18 : s == 1 ? 9 : s == 2 ? 4 : 2;
  endfunction

  function automatic logic [17:0] mread(input logic [1:0] s, input logic [8:0] a);
    int base = (int'(a) % (64 << s)) * wid(s);
    logic [17:0] v = 0;
    for (int i = 0; i < wid(s); i++) v[i] = model[base + i];
    return v;
  endfunction

  task automatic check(input string t, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected %h", t, act, exp);
    end
  endtask

  task automatic cyc();
    logic [17:0] old;
    @(posedge clk);
    old = mread(shape, rd_addr);
    if (!rrst_n) exp_q = 0;
    else if (rd_en) exp_q = old;
    if (wr_en) begin
      int base = (int'(wr_addr) % (64 << shape)) * wid(shape);
      for (int i = 0; i < wid(shape); i++) model[base + i] = wr_data[i];
    end
    #2;
    check(tag, rd_data, direct_rd ? mread(shape, rd_addr) : exp_q);
    @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [17:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; rd_en = 0; cyc(); wr_en = 0;
  endtask

  task automatic rd(input logic [8:0] a);
    rd_en = 1; rd_addr = a; cyc(); rd_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R11"; cyc(); cyc();
    check("R11 reset value", rd_data, 18'h0);
    rrst_n = 1;
    // R1 R6: every shape, walking and derived patterns
    for (int s = 0; s < 4; s++) begin
      shape = 2'(s); tag = "R1";
      for (int k = 0; k < 12; k++) wr(9'(k * 5), 18'(1 << k) ^ 18'(k * 18'h2D5B));
      tag = "R6";
      for (int k = 0; k < 12; k++) rd(9'(k * 5));
      tag = "R4";
      wr(9'd7, 18'h3FFFF); rd(9'd7);
      check("R4 high lanes zero", rd_data >> wid(shape), 18'h0);
    end
    // R7 hold with enable low
    shape = 0; tag = "R7";
    wr(9'd3, 18'h2AAAA); rd(9'd3);
    rd_addr = 9'd5; cyc(); cyc();
    check("R7 held value", rd_data, mread(2'd0, 9'd3));
    // R5 write with enable low
    tag = "R5";
    wr_en = 0; wr_addr = 9'd3; wr_data = 18'h15555; cyc();
    rd(9'd3);
    check("R5 unchanged", rd_data, 18'h2AAAA);
    // R3 high address bits ignored
    tag = "R3";
    wr(9'h1C5, 18'h0BEEF); rd(9'd5);
    check("R3 aliased write", rd_data, 18'h0BEEF);
    shape = 1; wr(9'h185, 18'h1A5); rd(9'd5);
    check("R3 aliased 128", rd_data, 18'h1A5);
    // R2 R10 cross shape readback
    shape = 0; tag = "R10";
    wr(9'd1, 18'h3A5C3);
    shape = 3;
    for (int k = 9; k < 18; k++) begin
      rd(9'(k));
      check("R2 2-bit slice", rd_data, {16'h0, 2'(18'h3A5C3 >> ((k - 9) * 2))});
    end
    shape = 2; rd(9'd5);
    check("R10 4-bit slice", rd_data, {14'h0, 4'(18'h3A5C3 >> 2)});
    // R2 top region unreachable in narrow shapes
    shape = 0; wr(9'd63, 18'h3FFFF);
    shape = 3; wr(9'd511, 18'h0); shape = 0; rd(9'd63);
    check("R2 top word intact", rd_data, {2'b11, 16'hFFFF} & 18'h3FFFF);
    // R9 same word both ports same edge
    shape = 1; tag = "R9";
    wr(9'd20, 18'h055);
    wr_en = 1; wr_addr = 9'd20; wr_data = 18'h1AA; rd_en = 1; rd_addr = 9'd20; cyc();
    wr_en = 0; rd_en = 0;
    check("R9 old data", rd_data, 18'h055);
    rd(9'd20);
    check("R9 new data later", rd_data, 18'h1AA);
    // R8 direct read follows address without a clock
    direct_rd = 1; tag = "R8";
    for (int k = 0; k < 6; k++) begin
      rd_addr = 9'(k * 5); #1;
      check("R8 unclocked", rd_data, mread(shape, rd_addr));
    end
    wr(9'd0, 18'h123); cyc();
    direct_rd = 0; tag = "R6"; cyc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule